// File: doc/BRIEF.md
# Host port interface slave

This block gives an external host processor indirect access to a shared on-chip word memory. The host never presents a memory address on its bus. Instead, two select lines steer each strobed access to one of four targets: a control/status register, an address register, the data latch with auto-increment, or the data latch with a fixed address. Each 16-bit target moves as two 8-bit halves, and a half-word select marks which half an access carries.

Memory traffic goes through the data latch. A write lands in memory only after both halves are latched. A read fetches the whole word when its first half is requested. While a commit or a fetch is completing, a ready output drops for one cycle. Strobes that arrive while ready is low, or that carry the wrong half, are dropped and recorded in a sticky error bit. A local processor-side port reaches the second port of the dual-port memory directly, and it can also read and write the control/status register.

Top module: `hostport_top`

## Requirements
- R1: After a synchronous active-low reset, ready is 1, the address register is 0, the control/status register reads 0x0001 (control byte 0, error 0, ready 1) and the half-word sequencer expects the first half.
- R2: The select value {h_sel[1],h_sel[0]} picks the host target. 2'b00 is the control/status register, 2'b01 is the address register, 2'b10 is the data latch with auto-increment and 2'b11 is the data latch with no increment. While h_half is 0, h_rdata shows bits 7:0 of the selected target, and while it is 1 it shows bits 15:8, with no strobe needed.
- R3: An accepted host write to the address register loads bits 7:0 when h_half is 0 and bits 15:8 when h_half is 1.
- R4: Accepting the second-half data write sets ready to 0 for exactly the next cycle. At the end of that cycle the word {high, low} is stored at location (address mod DEPTH). With select 2'b10 the address then advances by one, and with 2'b11 it is unchanged.
- R5: Accepting a first-half data read sets ready to 0 for one cycle, after which the latch holds the word stored at (address mod DEPTH). With select 2'b10, the accepted second-half read advances the address. Nothing else in a read advances it.
- R6: While ready is 0, any host strobe is ignored, and control/status bit 1 (error) is set.
- R7: A data-latch access whose h_half differs from the half the sequencer expects is ignored and sets the error bit. The sequencer expects the second half only after an accepted first half.
- R8: The error bit clears when the host writes a 1 to bit 1 with a first-half control/status write, or when the local side writes a 1 to bit 1. A set in the same cycle takes priority over a clear.
- R9: Control/status bits 15:8 form a control byte. The host writes it with a second-half write and the local side with a full-word write. When both write in the same cycle, the host value is kept.
- R10: The local port writes memory and the control/status register (l_csr=1) with one-cycle access. Read data appears on l_rdata in the cycle after l_en. When a host commit and a local write hit the same location in the same cycle, the host word is kept.
- R11: An address increment from location DEPTH-1 yields 0. Address register bits above the memory index do not take part in memory addressing, and an increment clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_sel | input | 2 | Host target select |
| h_half | input | 1 | Half-word select: 0 first (low), 1 second (high) |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wdata | input | WORD_W/2 | Host write half-word |
| h_rdata | output | WORD_W/2 | Selected half of the selected target |
| h_ready | output | 1 | Port can accept the next host access |
| l_en | input | 1 | Local access enable |
| l_we | input | 1 | Local write enable |
| l_csr | input | 1 | Local access targets the control/status register |
| l_addr | input | $clog2(DEPTH) | Local memory location |
| l_wdata | input | WORD_W | Local write word |
| l_rdata | output | WORD_W | Local read word, valid the cycle after l_en |

## Verification
The bench builds the block with WORD_W=16 and DEPTH=16. The small depth lets a single auto-increment word wrap the address from 15 to 0. It also lets an address register value of 0x0013 reach location 3, which exercises the modulo rule and the clearing of the upper bits within a few transfers. The whole memory can be preloaded from the local port, so every host read has a known expected value. The bench also times host commits against local writes so that both ports hit the same location in the same cycle.

// File: rtl/hostport_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the host port slave.
// Assumes the host select code is {h_sel[1], h_sel[0]}.
package hostport_pkg;

    // Host access target; the auto-increment code has bit1=1, bit0=0.
    typedef enum logic [1:0] {
        SEL_CSR      = 2'b00,
        SEL_ADDR     = 2'b01,
        SEL_DATA_INC = 2'b10,
        SEL_DATA_FIX = 2'b11
    } hsel_e;

    // Status bit positions inside the control/status word.
    localparam int CSR_READY_BIT = 0;
    localparam int CSR_ERR_BIT   = 1;

endpackage

// File: rtl/hostport_dpram.sv
`timescale 1ns/1ps
// Two-port word memory with registered read data on both ports.
// Each port reads before it writes. When both ports write the same location in
// one cycle, port A (host) wins because its write comes last.
// Assumes DEPTH is a power of two. The contents are not reset.
module hostport_dpram #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [AW-1:0]     a_addr,
    input  logic [WORD_W-1:0] a_wdata,
    output logic [WORD_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [AW-1:0]     b_addr,
    input  logic [WORD_W-1:0] b_wdata,
    output logic [WORD_W-1:0] b_rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Serve both ports; port A is written after port B so it wins a collision.
    always_ff @(posedge clk) begin
        if (b_en) begin
            b_rdata <= mem[b_addr];
            if (b_we) begin
                mem[b_addr] <= b_wdata;
            end
        end
        if (a_en) begin
            a_rdata <= mem[a_addr];
            if (a_we) begin
                mem[a_addr] <= a_wdata;
            end
        end
    end

endmodule

// File: rtl/hostport_hostctl.sv
`timescale 1ns/1ps
// Host-side access engine. It holds the address register, the data latch, the
// half-word sequencer and the ready flag. It decodes strobed host accesses and
// drives the host port of the shared memory.
// Assumes one-cycle strobes and DEPTH a power of two no larger than 2**WORD_W.
// When h_wr and h_rd are both high, the access is treated as a write.
module hostport_hostctl
    import hostport_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 1024,
    localparam int HW    = WORD_W / 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hsel_e             h_sel,
    input  logic              h_half,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [HW-1:0]     h_wdata,
    output logic [HW-1:0]     h_rdata,
    input  logic [WORD_W-1:0] csr_value,
    output logic              ready,
    output logic              err_pulse,
    output logic              csr_wr_lo,
    output logic              csr_wr_hi,
    output logic              ram_en,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    input  logic [WORD_W-1:0] ram_rdata
);

    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] latch_q;
    logic              expect_hi_q;
    logic              ready_q;
    logic              commit_q;
    logic              fetch_q;
    logic              inc_q;

    logic              strobe, accept, busy_hit, is_data, is_auto, order_bad, go;
    logic              data_wr_lo, data_wr_hi, data_rd_lo, data_rd_hi, addr_wr;
    logic [AW-1:0]     ram_idx, idx_plus;
    logic [WORD_W-1:0] addr_inc, sel_word;

    // Classify the current strobe and decide whether it takes effect.
    always_comb begin
        strobe     = h_wr | h_rd;
        is_data    = (h_sel == SEL_DATA_INC) || (h_sel == SEL_DATA_FIX);
        is_auto    = (h_sel == SEL_DATA_INC);
        accept     = strobe & ready_q;
        busy_hit   = strobe & ~ready_q;
        order_bad  = accept & is_data & (h_half != expect_hi_q);
        go         = accept & ~order_bad;
        err_pulse  = busy_hit | order_bad;
        data_wr_lo = go & is_data & h_wr & ~h_half;
        data_wr_hi = go & is_data & h_wr & h_half;
        data_rd_lo = go & is_data & ~h_wr & h_rd & ~h_half;
        data_rd_hi = go & is_data & ~h_wr & h_rd & h_half;
        addr_wr    = go & h_wr & (h_sel == SEL_ADDR);
        csr_wr_lo  = go & h_wr & (h_sel == SEL_CSR) & ~h_half;
        csr_wr_hi  = go & h_wr & (h_sel == SEL_CSR) & h_half;
    end

    // Memory index is the address modulo DEPTH; an increment wraps inside it.
    assign ram_idx  = addr_q[AW-1:0];
    assign idx_plus = ram_idx + 1'b1;
    assign addr_inc = WORD_W'(idx_plus);

    // Host memory port: a commit writes the latch, a first-half read fetches.
    assign ram_en    = commit_q | data_rd_lo;
    assign ram_we    = commit_q;
    assign ram_addr  = ram_idx;
    assign ram_wdata = latch_q;
    assign ready     = ready_q;

    // Track the pending commit or fetch and the ready flag they lower.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q  <= 1'b1;
            commit_q <= 1'b0;
            fetch_q  <= 1'b0;
            inc_q    <= 1'b0;
        end else begin
            commit_q <= data_wr_hi;
            fetch_q  <= data_rd_lo;
            if (data_wr_hi) begin
                inc_q <= is_auto;
            end
            if (data_wr_hi || data_rd_lo) begin
                ready_q <= 1'b0;
            end else if (commit_q || fetch_q) begin
                ready_q <= 1'b1;
            end
        end
    end

    // Half-word sequencer: expect the second half only after an accepted first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_hi_q <= 1'b0;
        end else if (data_wr_lo || data_rd_lo) begin
            expect_hi_q <= 1'b1;
        end else if (data_wr_hi || data_rd_hi) begin
            expect_hi_q <= 1'b0;
        end
    end

    // Data latch: host halves on writes, a whole memory word on a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (fetch_q) begin
            latch_q <= ram_rdata;
        end else if (data_wr_lo) begin
            latch_q[HW-1:0] <= h_wdata;
        end else if (data_wr_hi) begin
            latch_q[WORD_W-1:HW] <= h_wdata;
        end
    end

    // Address register: host half writes, or increment after a completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_wr) begin
            if (h_half) begin
                addr_q[WORD_W-1:HW] <= h_wdata;
            end else begin
                addr_q[HW-1:0] <= h_wdata;
            end
        end else if ((commit_q && inc_q) || (data_rd_hi && is_auto)) begin
            addr_q <= addr_inc;
        end
    end

    // Host read mux: selected target, then selected half.
    always_comb begin
        case (h_sel)
            SEL_CSR:  sel_word = csr_value;
            SEL_ADDR: sel_word = addr_q;
            default:  sel_word = latch_q;
        endcase
        h_rdata = h_half ? sel_word[WORD_W-1:HW] : sel_word[HW-1:0];
    end

    // R4: ready is never low for two cycles in a row.
    p_ready_recovers_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_q |=> ready_q);

    // R4: an accepted second-half write is followed by a memory write while not ready.
    p_commit_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_hi |=> (ram_we && !ready_q));

    // R6: a busy strobe leaves the address and the sequencer alone.
    p_busy_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_hit && !(commit_q && inc_q)) |=> ($stable(addr_q) && $stable(expect_hi_q)));

    // R7: an out-of-order half changes neither the latch nor the address.
    p_order_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        order_bad |=> ($stable(latch_q) && $stable(addr_q)));

    // R11: incrementing from the last location wraps to zero.
    p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_q && inc_q && ram_idx == AW'(DEPTH - 1)) |=> (addr_q == '0));

endmodule

// File: rtl/hostport_csr.sv
`timescale 1ns/1ps
// Control/status register shared by the host and the local side.
// Bit 0 mirrors ready, bit 1 is the sticky access error (set wins over a
// write-one-to-clear), and the upper half is a control byte in which a
// same-cycle host write beats a local write.
// Assumes WORD_W/2 is at least 3, so that a zero field lies between the status bits and the control byte.
module hostport_csr
    import hostport_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int HW    = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              err_set,
    input  logic              h_wr_lo,
    input  logic              h_wr_hi,
    input  logic [HW-1:0]     h_wdata,
    input  logic              l_wr,
    input  logic [WORD_W-1:0] l_wdata,
    output logic [WORD_W-1:0] csr_value
);

    logic [HW-1:0] ctl_q;
    logic          err_q;
    logic          err_clr;

    assign err_clr = (h_wr_lo && h_wdata[CSR_ERR_BIT]) || (l_wr && l_wdata[CSR_ERR_BIT]);

    // Sticky error: a new error outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_set) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    // Control byte: host write has priority over a local write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (h_wr_hi) begin
            ctl_q <= h_wdata;
        end else if (l_wr) begin
            ctl_q <= l_wdata[WORD_W-1:HW];
        end
    end

    assign csr_value = {ctl_q, {(HW-2){1'b0}}, err_q, ready};

    // R6: a reported access error shows up as the sticky bit.
    p_err_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> csr_value[CSR_ERR_BIT]);

    // R9: on a same-cycle write the host control byte is kept.
    p_host_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr_hi && l_wr) |=> (ctl_q == $past(h_wdata)));

endmodule

// File: rtl/hostport_top.sv
`timescale 1ns/1ps
// Host port slave top. The host reaches the shared memory through the address
// register and the data latch. The local side reaches the memory's second port
// and the control/status register with one-cycle registered reads.
// Assumes DEPTH is a power of two and WORD_W is even.
module hostport_top
    import hostport_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               h_sel,
    input  logic                     h_half,
    input  logic                     h_wr,
    input  logic                     h_rd,
    input  logic [WORD_W/2-1:0]      h_wdata,
    output logic [WORD_W/2-1:0]      h_rdata,
    output logic                     h_ready,
    input  logic                     l_en,
    input  logic                     l_we,
    input  logic                     l_csr,
    input  logic [$clog2(DEPTH)-1:0] l_addr,
    input  logic [WORD_W-1:0]        l_wdata,
    output logic [WORD_W-1:0]        l_rdata
);

    localparam int AW = $clog2(DEPTH);

    logic              ready, err_pulse, csr_wr_lo, csr_wr_hi;
    logic              ram_en, ram_we;
    logic [AW-1:0]     ram_addr;
    logic [WORD_W-1:0] ram_wdata, ram_rdata, b_rdata, csr_value, csr_rd_q;
    logic              l_csr_q;
    logic              l_csr_wr;

    assign l_csr_wr = l_en & l_we & l_csr;
    assign h_ready  = ready;

    hostport_hostctl #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_hostctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .h_sel     (hsel_e'(h_sel)),
        .h_half    (h_half),
        .h_wr      (h_wr),
        .h_rd      (h_rd),
        .h_wdata   (h_wdata),
        .h_rdata   (h_rdata),
        .csr_value (csr_value),
        .ready     (ready),
        .err_pulse (err_pulse),
        .csr_wr_lo (csr_wr_lo),
        .csr_wr_hi (csr_wr_hi),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata)
    );

    hostport_csr #(.WORD_W(WORD_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .err_set   (err_pulse),
        .h_wr_lo   (csr_wr_lo),
        .h_wr_hi   (csr_wr_hi),
        .h_wdata   (h_wdata),
        .l_wr      (l_csr_wr),
        .l_wdata   (l_wdata),
        .csr_value (csr_value)
    );

    hostport_dpram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .a_en    (ram_en),
        .a_we    (ram_we),
        .a_addr  (ram_addr),
        .a_wdata (ram_wdata),
        .a_rdata (ram_rdata),
        .b_en    (l_en & ~l_csr),
        .b_we    (l_we),
        .b_addr  (l_addr),
        .b_wdata (l_wdata),
        .b_rdata (b_rdata)
    );

    // Local read path: remember the target and capture the register value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_csr_q  <= 1'b0;
            csr_rd_q <= '0;
        end else if (l_en) begin
            l_csr_q <= l_csr;
            if (l_csr) begin
                csr_rd_q <= csr_value;
            end
        end
    end

    assign l_rdata = l_csr_q ? csr_rd_q : b_rdata;

endmodule

// File: tb/hostport_top_tb_top.sv
`timescale 1ns/1ps
// Bench for hostport_top: a behavioural reference model updated on every rising
// edge and compared at every falling edge, plus directed checks per requirement.
module hostport_top_tb_top;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  h_sel = 2'b00;
    logic        h_half = 1'b0, h_wr = 1'b0, h_rd = 1'b0;
    logic [7:0]  h_wdata = 8'h00;
    logic [7:0]  h_rdata;
    logic        h_ready;
    logic        l_en = 1'b0, l_we = 1'b0, l_csr = 1'b0;
    logic [3:0]  l_addr = 4'h0;
    logic [15:0] l_wdata = 16'h0;
    logic [15:0] l_rdata;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    hostport_top #(.WORD_W(16), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_half(h_half), .h_wr(h_wr),
        .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready),
        .l_en(l_en), .l_we(l_we), .l_csr(l_csr), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [15:0] m_addr, m_latch, m_fetch, m_lrd, m_csr_old, m_fetch_val;
    logic [15:0] m_mem [D];
    logic [7:0]  m_ctl;
    bit          m_exp, m_ready, m_commit, m_fetchp, m_inc, m_err, m_lrd_valid;
    bit          rdy_old, set_err, clr_err, host_ctl;

    // Model update from the inputs present at this edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 16'h0; m_latch = 16'h0; m_exp = 0; m_ready = 1; m_commit = 0;
            m_fetchp = 0; m_inc = 0; m_err = 0; m_ctl = 8'h0; m_lrd_valid = 0;
        end else begin
            rdy_old = m_ready; set_err = 0; clr_err = 0; host_ctl = 0;
            m_csr_old = {m_ctl, 6'b0, m_err, m_ready};
            m_fetch_val = m_mem[m_addr % D];
            m_lrd_valid = l_en;
            if (l_en) m_lrd = l_csr ? m_csr_old : m_mem[l_addr];
            if (l_en && l_we && !l_csr) m_mem[l_addr] = l_wdata;
            if (m_commit) begin
                m_mem[m_addr % D] = m_latch;
                if (m_inc) m_addr = 16'(((m_addr % D) + 1) % D);
                m_ready = 1; m_commit = 0;
            end
            if (m_fetchp) begin
                m_latch = m_fetch; m_ready = 1; m_fetchp = 0;
            end
            if (h_wr || h_rd) begin
                if (!rdy_old) set_err = 1;
                else if (h_sel == 2'b00) begin
                    if (h_wr && !h_half && h_wdata[1]) clr_err = 1;
                    if (h_wr && h_half) begin m_ctl = h_wdata; host_ctl = 1; end
                end else if (h_sel == 2'b01) begin
                    if (h_wr && !h_half) m_addr[7:0] = h_wdata;
                    if (h_wr && h_half) m_addr[15:8] = h_wdata;
                end else if (h_half != m_exp) set_err = 1;
                else if (h_wr) begin
                    if (!h_half) begin m_latch[7:0] = h_wdata; m_exp = 1; end
                    else begin
                        m_latch[15:8] = h_wdata; m_exp = 0; m_commit = 1;
                        m_inc = (h_sel == 2'b10); m_ready = 0;
                    end
                end else begin
                    if (!h_half) begin m_fetch = m_fetch_val; m_fetchp = 1; m_ready = 0; m_exp = 1; end
                    else begin
                        m_exp = 0;
                        if (h_sel == 2'b10) m_addr = 16'(((m_addr % D) + 1) % D);
                    end
                end
            end
            if (l_en && l_we && l_csr) begin
                if (l_wdata[1]) clr_err = 1;
                if (!host_ctl) m_ctl = l_wdata[15:8];
            end
            if (set_err) m_err = 1;
            else if (clr_err) m_err = 0;
        end
    end

    // Compare the model with the outputs away from the rising edge.
    logic [15:0] m_word;
    always @(negedge clk) begin
        if (rst_n) begin
            case (h_sel)
                2'b00:   m_word = {m_ctl, 6'b0, m_err, m_ready};
                2'b01:   m_word = m_addr;
                default: m_word = m_latch;
            endcase
            check("R4 model ready", 32'(h_ready), 32'(m_ready));
            check("R2 model h_rdata", 32'(h_rdata), 32'(h_half ? m_word[15:8] : m_word[7:0]));
            if (m_lrd_valid) check("R10 model l_rdata", 32'(l_rdata), 32'(m_lrd));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic host_acc(input logic [1:0] s, input logic hf, input logic wr, input logic [7:0] d);
        h_sel = s; h_half = hf; h_wr = wr; h_rd = !wr; h_wdata = d;
        cyc();
        h_wr = 0; h_rd = 0;
    endtask

    task automatic local_acc(input logic csr, input logic we, input logic [3:0] a, input logic [15:0] d);
        l_en = 1; l_csr = csr; l_we = we; l_addr = a; l_wdata = d;
        cyc();
        l_en = 0; l_we = 0; l_csr = 0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [15:0] v);
        h_sel = s; h_half = 0; #1 v[7:0] = h_rdata;
        h_half = 1; #1 v[15:8] = h_rdata;
    endtask

    task automatic set_addr(input logic [15:0] a);
        host_acc(2'b01, 0, 1, a[7:0]);
        host_acc(2'b01, 1, 1, a[15:8]);
    endtask

    logic [15:0] v;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2000000;
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1: reset state
        check("R1 ready", 32'(h_ready), 1);
        peek(2'b00, v); check("R1 csr", 32'(v), 32'h0001);
        peek(2'b01, v); check("R1 addr", 32'(v), 0);
        // preload memory from the local side
        for (int i = 0; i < D; i++) local_acc(0, 1, 4'(i), 16'hA000 + 16'(i));
        local_acc(0, 0, 4'd5, 16'h0); check("R10 local read", 32'(l_rdata), 32'hA005);
        // R3: address register halves
        set_addr(16'h0003);
        peek(2'b01, v); check("R3 addr write", 32'(v), 32'h0003);
        // R4: auto-increment write
        host_acc(2'b10, 0, 1, 8'hEF);
        host_acc(2'b10, 1, 1, 8'hBE);
        check("R4 ready low in commit", 32'(h_ready), 0);
        cyc();
        check("R4 ready back", 32'(h_ready), 1);
        peek(2'b01, v); check("R4 addr advanced", 32'(v), 32'h0004);
        local_acc(0, 0, 4'd3, 16'h0); check("R4 word stored", 32'(l_rdata), 32'hBEEF);
        // R4: fixed write
        host_acc(2'b11, 0, 1, 8'h34);
        host_acc(2'b11, 1, 1, 8'h12);
        cyc();
        peek(2'b01, v); check("R4 fixed addr kept", 32'(v), 32'h0004);
        local_acc(0, 0, 4'd4, 16'h0); check("R4 fixed stored", 32'(l_rdata), 32'h1234);
        // R5: auto-increment read
        host_acc(2'b10, 0, 0, 8'h00);
        check("R5 ready low in fetch", 32'(h_ready), 0);
        cyc();
        peek(2'b10, v); check("R5 latch word", 32'(v), 32'h1234);
        peek(2'b01, v); check("R5 addr before second half", 32'(v), 32'h0004);
        host_acc(2'b10, 1, 0, 8'h00);
        peek(2'b01, v); check("R5 addr after second half", 32'(v), 32'h0005);
        // R5: fixed read
        host_acc(2'b11, 0, 0, 8'h00);
        cyc();
        peek(2'b11, v); check("R5 fixed latch", 32'(v), 32'hA005);
        host_acc(2'b11, 1, 0, 8'h00);
        peek(2'b01, v); check("R5 fixed addr kept", 32'(v), 32'h0005);
        // R6: strobe while not ready
        host_acc(2'b11, 0, 1, 8'h11);
        host_acc(2'b11, 1, 1, 8'h22);
        host_acc(2'b01, 0, 1, 8'h0F);
        peek(2'b01, v); check("R6 busy write ignored", 32'(v), 32'h0005);
        peek(2'b00, v); check("R6 error set", 32'(v), 32'h0003);
        local_acc(0, 0, 4'd5, 16'h0); check("R6 commit intact", 32'(l_rdata), 32'h2211);
        // R8: host clear
        host_acc(2'b00, 0, 1, 8'h02);
        peek(2'b00, v); check("R8 host clear", 32'(v), 32'h0001);
        // R7: out-of-order half
        host_acc(2'b10, 1, 1, 8'h77);
        peek(2'b00, v); check("R7 error set", 32'(v), 32'h0003);
        peek(2'b01, v); check("R7 addr kept", 32'(v), 32'h0005);
        local_acc(0, 0, 4'd5, 16'h0); check("R7 memory kept", 32'(l_rdata), 32'h2211);
        // R8: local clear
        local_acc(1, 1, 4'd0, 16'h0002);
        peek(2'b00, v); check("R8 local clear", 32'(v), 32'h0001);
        // R8: set beats clear in the same cycle
        host_acc(2'b11, 0, 1, 8'h33);
        host_acc(2'b11, 1, 1, 8'h44);
        h_sel = 2'b01; h_half = 0; h_wr = 1; h_wdata = 8'h09;
        l_en = 1; l_csr = 1; l_we = 1; l_wdata = 16'h0002;
        cyc();
        h_wr = 0; l_en = 0; l_csr = 0; l_we = 0;
        peek(2'b00, v); check("R8 set wins", 32'(v), 32'h0003);
        host_acc(2'b00, 0, 1, 8'h02);
        // R9: control byte
        local_acc(1, 1, 4'd0, 16'h5A00);
        peek(2'b00, v); check("R9 local ctl", 32'(v), 32'h5A01);
        h_sel = 2'b00; h_half = 1; h_wr = 1; h_wdata = 8'hC3;
        l_en = 1; l_csr = 1; l_we = 1; l_wdata = 16'h7700;
        cyc();
        h_wr = 0; l_en = 0; l_csr = 0; l_we = 0;
        peek(2'b00, v); check("R9 host wins", 32'(v), 32'hC301);
        local_acc(1, 0, 4'd0, 16'h0); check("R9 local csr read", 32'(l_rdata), 32'hC301);
        // R11: wrap from the last location
        set_addr(16'h000F);
        host_acc(2'b10, 0, 1, 8'h88);
        host_acc(2'b10, 1, 1, 8'h99);
        cyc();
        peek(2'b01, v); check("R11 wrap to zero", 32'(v), 32'h0000);
        local_acc(0, 0, 4'd15, 16'h0); check("R11 last stored", 32'(l_rdata), 32'h9988);
        // R11: upper address bits ignored, cleared by increment
        set_addr(16'h0013);
        host_acc(2'b11, 0, 1, 8'h55);
        host_acc(2'b11, 1, 1, 8'h66);
        cyc();
        local_acc(0, 0, 4'd3, 16'h0); check("R11 modulo location", 32'(l_rdata), 32'h6655);
        host_acc(2'b10, 0, 0, 8'h00);
        cyc();
        host_acc(2'b10, 1, 0, 8'h00);
        peek(2'b01, v); check("R11 increment clears upper", 32'(v), 32'h0004);
        // R10: same-location collision, host kept
        set_addr(16'h0007);
        host_acc(2'b11, 0, 1, 8'hCD);
        host_acc(2'b11, 1, 1, 8'hAB);
        local_acc(0, 1, 4'd7, 16'h1111);
        local_acc(0, 0, 4'd7, 16'h0); check("R10 host wins collision", 32'(l_rdata), 32'hABCD);
        local_acc(0, 1, 4'd8, 16'h2468);
        local_acc(0, 0, 4'd8, 16'h0); check("R10 local write", 32'(l_rdata), 32'h2468);
        cyc();
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule